// File: doc/BRIEF.md
# Sliding-Scale Coarse Time-to-Digital Back End

This block is the clocked digital half of a coarse time-to-digital converter. The other half is a ring of four differential delay cells, and each cell step is 50 ps. The ring stays stopped until a measurement begins. When a start trigger arrives, the block enables the ring from an initial phase that the block itself selects. While the ring runs, a small counter records each completed lap, reported by a one-cycle lap strobe. When a stop trigger arrives, the block samples the ring's phase taps and the lap count, decodes the tap pattern to a phase index, and forms a 5-bit coarse code. The code spans 32 steps of 50 ps, which is 1.6 ns. One more lap-counter bit doubles that span.

To spread cell-mismatch errors across all codes, every measurement starts the ring from a different pseudo-random phase. The phase comes from an 8-bit maximal-length LFSR. The block subtracts that start phase from the result in the digital domain. Each result reports the start phase that was used, so downstream logic can check the subtraction or histogram it.

Top module: `sstdc_core`

## Requirements
- R1: When reset is released, `ring_en_o` and `res_valid_o` are 0 and `start_phase_o` equals the low 3 bits of the LFSR seed 8'h01, which is 3'd1.
- R2: A `start_i` pulse while idle raises `ring_en_o` on the next cycle and clears the lap counter.
- R3: A `start_i` pulse while the ring is running, or during the result cycle, has no effect: the lap count keeps accumulating and the run continues.
- R4: A `stop_i` with no run in progress is ignored: no result appears and the LFSR does not advance. If `start_i` and `stop_i` arrive in the same idle cycle, the start is taken and the stop is dropped.
- R5: Each `lap_i` strobe in a running cycle increments a 2-bit lap counter, which wraps modulo 4. A strobe in the same cycle as `stop_i` is not counted.
- R6: The taps `taps_i[3:0]` decode to a phase as follows: 0000→0, 0001→1, 0011→2, 0111→3, 1111→4, 1110→5, 1100→6, 1000→7.
- R7: `res_code_o` = (laps·8 + decoded phase − start phase) mod 32.
- R8: Any tap pattern outside the R6 list sets `res_err_o` to 1 and forces `res_code_o` to 0.
- R9: `res_valid_o` is high for exactly the one cycle after the cycle in which `stop_i` is sampled while running. `ring_en_o` is low in that cycle, and the block accepts a new start in the cycle after it.
- R10: `res_phase_o` carries the start phase used by the measurement. The LFSR shifts left once per completed measurement, feeding in q[7]^q[5]^q[4]^q[3], and `start_phase_o` is its low 3 bits.
- R11: `start_phase_o` changes only at the clock edge that captures a result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start trigger, one cycle |
| stop_i | input | 1 | Stop trigger, one cycle |
| lap_i | input | 1 | One-cycle strobe per completed ring lap |
| taps_i | input | 4 | Ring cell outputs, sampled at stop |
| ring_en_o | output | 1 | Ring enable |
| start_phase_o | output | 3 | Initial phase loaded into the ring |
| res_valid_o | output | 1 | Result strobe |
| res_code_o | output | 5 | Offset-corrected coarse code |
| res_phase_o | output | 3 | Start phase used by this result |
| res_err_o | output | 1 | Illegal tap pattern flag |

## Verification
Two collisions matter most.

- **Stop with a lap strobe.** The capture and the lap counter can act in the same cycle when `lap_i` and `stop_i` arrive together. The bench drives both together after two earlier laps and expects the code to reflect two laps, not three.
- **Start with stop while idle.** Arming and the stop filter both see the same cycle when `start_i` and `stop_i` arrive together in idle. The bench expects the ring to run with no result, then completes that run and checks the code.

A start pulse inside a run is also checked for leaving the lap count intact.

// File: rtl/sstdc_pkg.sv
package sstdc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } sstdc_state_e;

    // Fibonacci step: shift left, feed the parity of the tapped bits into bit 0.
    function automatic logic [31:0] lfsr_step(input logic [31:0] q,
                                              input logic [31:0] taps,
                                              input int unsigned width);
        logic fb;
        fb = ^(q & taps);
        return ((q << 1) | {31'd0, fb}) & ((32'd1 << width) - 32'd1);
    endfunction

    // Tap pattern of phase k in a ring of n inverting stages (Johnson order).
    function automatic logic [31:0] ring_pattern(input int unsigned k,
                                                 input int unsigned n);
        logic [31:0] full;
        full = (32'd1 << n) - 32'd1;
        if (k <= n)
            return (32'd1 << k) - 32'd1;
        else
            return full & ~((32'd1 << (k - n)) - 32'd1);
    endfunction

endpackage

// File: rtl/sstdc_phase_dec.sv
module sstdc_phase_dec #(
    parameter int NCELL = 4,
    parameter int PH_W  = $clog2(2 * NCELL)
) (
    input  logic [NCELL-1:0] taps_i,
    output logic [PH_W-1:0]  phase_o,
    output logic             err_o
);
    import sstdc_pkg::*;

    localparam int STATES = 2 * NCELL;

    logic [STATES-1:0] hit;

    for (genvar k = 0; k < STATES; k++) begin : g_match
        localparam logic [31:0] PAT = ring_pattern(k, NCELL);
        assign hit[k] = (taps_i == PAT[NCELL-1:0]);
    end

    always_comb begin
        phase_o = '0;
        for (int k = 0; k < STATES; k++) begin
            if (hit[k]) phase_o = PH_W'(k);
        end
    end

    assign err_o = ~|hit;

endmodule

// File: rtl/sstdc_lfsr.sv
module sstdc_lfsr #(
    parameter int          LFSR_W = 8,
    parameter logic [31:0] TAPS   = 32'h0000_00B8,
    parameter logic [31:0] SEED   = 32'h0000_0001,
    parameter int          OUT_W  = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv_i,
    output logic [OUT_W-1:0] sel_o
);
    import sstdc_pkg::*;

    logic [LFSR_W-1:0] q;

    always_ff @(posedge clk) begin
        if (rst)
            q <= SEED[LFSR_W-1:0];
        else if (adv_i)
            q <= LFSR_W'(lfsr_step(32'(q), TAPS, LFSR_W));
    end

    assign sel_o = q[OUT_W-1:0];

endmodule

// File: rtl/sstdc_ctrl.sv
module sstdc_ctrl #(
    parameter int LAP_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic             lap_i,
    output logic             run_o,
    output logic             cap_o,
    output logic [LAP_W-1:0] laps_o
);
    import sstdc_pkg::*;

    sstdc_state_e state, state_nx;
    logic         arm;

    assign arm   = (state == ST_IDLE) && start_i;
    assign run_o = (state == ST_RUN);
    assign cap_o = run_o && stop_i;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start_i) state_nx = ST_RUN;
            ST_RUN:  if (stop_i)  state_nx = ST_DONE;
            ST_DONE:              state_nx = ST_IDLE;
            default:              state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            laps_o <= '0;
        end else begin
            state <= state_nx;
            if (arm)
                laps_o <= '0;
            else if (run_o && lap_i && !stop_i)
                laps_o <= laps_o + LAP_W'(1);
        end
    end

endmodule

// File: rtl/sstdc_core.sv
module sstdc_core #(
    parameter int          NCELL     = 4,
    parameter int          LAP_W     = 2,
    parameter int          LFSR_W    = 8,
    parameter logic [31:0] LFSR_TAPS = 32'h0000_00B8,
    parameter logic [31:0] LFSR_SEED = 32'h0000_0001
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start_i,
    input  logic         stop_i,
    input  logic         lap_i,
    input  logic [3:0]   taps_i,
    output logic         ring_en_o,
    output logic [2:0]   start_phase_o,
    output logic         res_valid_o,
    output logic [4:0]   res_code_o,
    output logic [2:0]   res_phase_o,
    output logic         res_err_o
);
    // Phase steps per lap are 2*NCELL and must be a power of two so that
    // {laps, phase} is the linear step count.
    localparam int PH_W   = $clog2(2 * NCELL);
    localparam int CODE_W = LAP_W + PH_W;

    typedef struct packed {
        logic              err;
        logic [PH_W-1:0]   phase;
        logic [CODE_W-1:0] code;
    } sstdc_result_t;

    logic              run, cap;
    logic [LAP_W-1:0]  laps;
    logic [PH_W-1:0]   ph_dec, ph_start;
    logic              ph_err;
    logic [CODE_W-1:0] raw_steps;
    sstdc_result_t     res_nx, res_q;
    logic              valid_q;

    sstdc_ctrl #(.LAP_W(LAP_W)) ctrl_i (
        .clk    (clk),
        .rst    (rst),
        .start_i(start_i),
        .stop_i (stop_i),
        .lap_i  (lap_i),
        .run_o  (run),
        .cap_o  (cap),
        .laps_o (laps)
    );

    sstdc_phase_dec #(.NCELL(NCELL), .PH_W(PH_W)) dec_i (
        .taps_i (taps_i[NCELL-1:0]),
        .phase_o(ph_dec),
        .err_o  (ph_err)
    );

    sstdc_lfsr #(
        .LFSR_W(LFSR_W),
        .TAPS  (LFSR_TAPS),
        .SEED  (LFSR_SEED),
        .OUT_W (PH_W)
    ) lfsr_i (
        .clk  (clk),
        .rst  (rst),
        .adv_i(cap),
        .sel_o(ph_start)
    );

    assign raw_steps = {laps, ph_dec};

    always_comb begin
        res_nx.err   = ph_err;
        res_nx.phase = ph_start;
        res_nx.code  = ph_err ? '0 : raw_steps - CODE_W'(ph_start);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            res_q   <= '0;
        end else begin
            valid_q <= cap;
            if (cap) res_q <= res_nx;
        end
    end

    assign ring_en_o     = run;
    assign start_phase_o = 3'(ph_start);
    assign res_valid_o   = valid_q;
    assign res_code_o    = 5'(res_q.code);
    assign res_phase_o   = 3'(res_q.phase);
    assign res_err_o     = res_q.err;

endmodule

// File: rtl/sstdc_checker.sv
module sstdc_checker (
    input logic       clk,
    input logic       rst,
    input logic       start_i,
    input logic       stop_i,
    input logic       ring_en_o,
    input logic [2:0] start_phase_o,
    input logic       res_valid_o,
    input logic [4:0] res_code_o,
    input logic       res_err_o
);

    // R9: a result strobe never lasts two cycles
    a_r9_valid_single: assert property (@(posedge clk) disable iff (rst)
        res_valid_o |=> !res_valid_o);

    // R9: a stop taken during a run yields a result with the ring stopped
    a_r9_stop_to_result: assert property (@(posedge clk) disable iff (rst)
        (ring_en_o && stop_i) |=> (res_valid_o && !ring_en_o));

    // R4: a stop outside a run never produces a result
    a_r4_idle_stop_ignored: assert property (@(posedge clk) disable iff (rst)
        (!ring_en_o && stop_i) |=> !res_valid_o);

    // R2: the ring turns on only after a start trigger
    a_r2_enable_from_start: assert property (@(posedge clk) disable iff (rst)
        $rose(ring_en_o) |-> $past(start_i));

    // R8: an illegal pattern carries a zero code
    a_r8_err_zero_code: assert property (@(posedge clk) disable iff (rst)
        (res_valid_o && res_err_o) |-> (res_code_o == 5'd0));

    // R11: start phase moves only on a capture edge
    a_r11_phase_hold: assert property (@(posedge clk) disable iff (rst)
        !(ring_en_o && stop_i) |=> $stable(start_phase_o));

endmodule

bind sstdc_core sstdc_checker chk_i (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start_i),
    .stop_i       (stop_i),
    .ring_en_o    (ring_en_o),
    .start_phase_o(start_phase_o),
    .res_valid_o  (res_valid_o),
    .res_code_o   (res_code_o),
    .res_err_o    (res_err_o)
);

// File: tb/sstdc_core_tb.sv
module sstdc_core_tb_top;

    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst;
    logic       start_i, stop_i, lap_i;
    logic [3:0] taps_i;
    logic       ring_en_o, res_valid_o, res_err_o;
    logic [2:0] start_phase_o, res_phase_o;
    logic [4:0] res_code_o;

    int checks = 0;
    int errors = 0;
    logic [7:0] lfsr_m;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sstdc_core dut_i (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .stop_i       (stop_i),
        .lap_i        (lap_i),
        .taps_i       (taps_i),
        .ring_en_o    (ring_en_o),
        .start_phase_o(start_phase_o),
        .res_valid_o  (res_valid_o),
        .res_code_o   (res_code_o),
        .res_phase_o  (res_phase_o),
        .res_err_o    (res_err_o)
    );

    // {laps[2:0], taps[3:0], expected phase[2:0]}
    localparam logic [9:0] VEC [8] = '{
        {3'd0, 4'b0000, 3'd0}, {3'd1, 4'b0001, 3'd1},
        {3'd2, 4'b0011, 3'd2}, {3'd3, 4'b0111, 3'd3},
        {3'd0, 4'b1111, 3'd4}, {3'd1, 4'b1110, 3'd5},
        {3'd2, 4'b1100, 3'd6}, {3'd3, 4'b1000, 3'd7}
    };

    function automatic logic [7:0] model_adv(input logic [7:0] q);
        return {q[6:0], q[7] ^ q[5] ^ q[4] ^ q[3]};
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Full measurement: start, n laps, stop with the given taps.
    task automatic measure(input int nlaps, input logic [3:0] taps,
                           input int ph, input bit bad,
                           input bit lap_on_stop, input bit start_mid,
                           input bit skip_start);
        logic [2:0] sp;
        int exp_code;
        sp = lfsr_m[2:0];
        if (!skip_start) begin
            @(negedge clk);
            chk("R10 start phase", start_phase_o, sp);
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            chk("R2 ring enable", ring_en_o, 1);
        end
        for (int i = 0; i < nlaps; i++) begin
            lap_i   = 1'b1;
            start_i = start_mid && (i == 0);
            @(negedge clk);
            lap_i   = 1'b0;
            start_i = 1'b0;
        end
        chk("R11 phase held", start_phase_o, sp);
        chk("R3 still running", ring_en_o, 1);
        taps_i = taps;
        stop_i = 1'b1;
        lap_i  = lap_on_stop;
        @(negedge clk);
        stop_i = 1'b0;
        lap_i  = 1'b0;
        exp_code = bad ? 0 : (((nlaps % 4) * 8 + ph - sp) & 31);
        chk("R9 valid", res_valid_o, 1);
        chk("R9 ring off", ring_en_o, 0);
        chk("R7/R5 code", res_code_o, exp_code);
        chk("R8/R6 err", res_err_o, bad);
        chk("R10 phase used", res_phase_o, sp);
        lfsr_m = model_adv(lfsr_m);
        @(negedge clk);
        chk("R9 valid single", res_valid_o, 0);
        chk("R10 lfsr advance", start_phase_o, lfsr_m[2:0]);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; start_i = 0; stop_i = 0; lap_i = 0; taps_i = '0;
        lfsr_m = 8'h01;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 ring_en", ring_en_o, 0);
        chk("R1 valid", res_valid_o, 0);
        chk("R1 start phase", start_phase_o, 1);

        // Table walk: every legal phase, lap counts 0..3 (R6, R7)
        for (int v = 0; v < 8; v++)
            measure(VEC[v][9:7], VEC[v][6:3], VEC[v][2:0], 0, 0, 0, 0);

        // R5: lap counter wraps after four laps
        measure(5, 4'b0011, 2, 0, 0, 0, 0);
        // R5: lap strobe coinciding with stop not counted
        measure(2, 4'b0111, 3, 0, 1, 0, 0);
        // R3: start during run leaves count intact
        measure(3, 4'b1110, 5, 0, 0, 1, 0);
        // R8: bubble and other illegal patterns
        measure(1, 4'b0101, 0, 1, 0, 0, 0);
        measure(2, 4'b0010, 0, 1, 0, 0, 0);

        // R4: stop with no run is ignored
        @(negedge clk);
        stop_i = 1'b1;
        @(negedge clk);
        stop_i = 1'b0;
        chk("R4 no result", res_valid_o, 0);
        chk("R4 ring idle", ring_en_o, 0);
        @(negedge clk);
        chk("R4 no result later", res_valid_o, 0);
        chk("R4 lfsr unchanged", start_phase_o, lfsr_m[2:0]);

        // R4: start and stop in the same idle cycle, start wins
        start_i = 1'b1;
        stop_i  = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        stop_i  = 1'b0;
        chk("R4 start wins", ring_en_o, 1);
        chk("R4 no result", res_valid_o, 0);
        measure(1, 4'b1100, 6, 0, 0, 0, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule